// File: doc/BRIEF.md
# Triple Modular Redundancy Voter

This block takes three redundant copies of a data word, one from each of three replicated modules, and reduces them to a single word in which one faulty copy is masked. Two ways of voting are available, picked per sample by a mode input.

In bitwise mode, every output bit is the two-out-of-three majority of the matching input bits. This suits digital results that should be identical. In median mode, the three words are read as unsigned numbers and the middle one is passed on. This suits sensor-like readings, where the good copies may differ slightly and one wildly wrong value has to be thrown away.

With each voted word the block also reports which channels disagree with it, so that a supervisor can locate the faulty module. Results are registered, with one cycle from the input strobe to the output strobe.

Top module: `tmr_voter`

## Requirements
- R1: With `mode` = 0 (bitwise), every bit of `voted` is (a AND b) OR (a AND c) OR (b AND c), taken over the same bit of `chan_a`, `chan_b` and `chan_c`.
- R2: With `mode` = 0, if any one channel is corrupted in any bits while the other two agree, `voted` equals the value of the two agreeing channels.
- R3: With `mode` = 1 (median), `voted` is the middle value of the three inputs read as unsigned numbers. For example, inputs 99, 100 and 45217 give 100.
- R4: With `mode` = 1, when two or three inputs are equal, `voted` is that shared value.
- R5: `disagree[0]`, `disagree[1]` and `disagree[2]` are set exactly when `chan_a`, `chan_b` or `chan_c` respectively differs from the `voted` word produced from the same sample.
- R6: `any_fault` is high exactly when at least one `disagree` bit is high.
- R7: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low otherwise. `voted`, `disagree` and `any_fault` are updated on that same edge.
- R8: A cycle with `in_valid` low leaves `voted`, `disagree` and `any_fault` unchanged, whatever the channel and mode inputs are.
- R9: While `rst_n` is low, `out_valid`, `voted`, `disagree` and `any_fault` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| mode | input | 1 | 0 = bitwise majority, 1 = unsigned median |
| chan_a | input | WIDTH | Copy from replica A |
| chan_b | input | WIDTH | Copy from replica B |
| chan_c | input | WIDTH | Copy from replica C |
| out_valid | output | 1 | Voted result strobe, one cycle after `in_valid` |
| voted | output | WIDTH | Masked output word |
| disagree | output | 3 | Per-channel mismatch flags: bit 0 = A, bit 1 = B, bit 2 = C |
| any_fault | output | 1 | OR of the mismatch flags |

## Verification
The assertions take for granted that `mode` and the channel inputs are stable around the clock edge when `in_valid` is high. They also assume that `rst_n` is asserted from time zero, so that the history they look back on starts at reset.

The masking property for bitwise mode is only claimed when at least two channels agree. The stimulus therefore corrupts at most one channel in its masking patterns. Triples in which all three channels differ are used only for the R1 bit-level and R3 median checks, which make no masking claim.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NUM_CHAN = 3;

    typedef enum logic {
        VOTE_BITWISE = 1'b0,
        VOTE_MEDIAN  = 1'b1
    } vote_mode_e;
endpackage

// File: rtl/tmr_bit_majority.sv
module tmr_bit_majority #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic [WIDTH-1:0] in_c,
    output logic [WIDTH-1:0] maj
);
    // One AND level feeding one OR level per bit
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        logic p_ab, p_ac, p_bc;
        assign p_ab    = in_a[gi] & in_b[gi];
        assign p_ac    = in_a[gi] & in_c[gi];
        assign p_bc    = in_b[gi] & in_c[gi];
        assign maj[gi] = p_ab | p_ac | p_bc;
    end
endmodule

// File: rtl/tmr_median3.sv
module tmr_median3 #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic [WIDTH-1:0] in_c,
    output logic [WIDTH-1:0] mid
);
    logic a_ge_b, a_ge_c, b_ge_c;

    always_comb begin
        a_ge_b = (in_a >= in_b);
        a_ge_c = (in_a >= in_c);
        b_ge_c = (in_b >= in_c);
        if (a_ge_b) begin
            if (b_ge_c)      mid = in_b;
            else if (a_ge_c) mid = in_c;
            else             mid = in_a;
        end else begin
            if (a_ge_c)      mid = in_a;
            else if (b_ge_c) mid = in_c;
            else             mid = in_b;
        end
    end
endmodule

// File: rtl/tmr_disagree.sv
module tmr_disagree #(
    parameter int WIDTH = 16,
    parameter int CHANS = 3
) (
    input  logic [CHANS-1:0][WIDTH-1:0] chans,
    input  logic [WIDTH-1:0]            ref_word,
    output logic [CHANS-1:0]            flags
);
    for (genvar gc = 0; gc < CHANS; gc++) begin : g_chan
        assign flags[gc] = (chans[gc] != ref_word);
    end
endmodule

// File: rtl/tmr_voter.sv
module tmr_voter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             mode,
    input  logic [WIDTH-1:0] chan_a,
    input  logic [WIDTH-1:0] chan_b,
    input  logic [WIDTH-1:0] chan_c,
    output logic             out_valid,
    output logic [WIDTH-1:0] voted,
    output logic [2:0]       disagree,
    output logic             any_fault
);
    import tmr_pkg::*;

    typedef struct packed {
        logic                vld;
        logic [WIDTH-1:0]    word;
        logic [NUM_CHAN-1:0] dis;
        logic                any;
    } vote_state_t;

    vote_state_t state_d, state_q;

    logic [WIDTH-1:0]               maj_word, med_word, pick_word;
    logic [NUM_CHAN-1:0][WIDTH-1:0] chan_vec;
    logic [NUM_CHAN-1:0]            flag_vec;
    vote_mode_e                     mode_sel;

    assign chan_vec = {chan_c, chan_b, chan_a};
    assign mode_sel = vote_mode_e'(mode);

    tmr_bit_majority #(.WIDTH(WIDTH)) u_majority (
        .in_a(chan_a), .in_b(chan_b), .in_c(chan_c), .maj(maj_word)
    );

    tmr_median3 #(.WIDTH(WIDTH)) u_median (
        .in_a(chan_a), .in_b(chan_b), .in_c(chan_c), .mid(med_word)
    );

    assign pick_word = (mode_sel == VOTE_MEDIAN) ? med_word : maj_word;

    tmr_disagree #(.WIDTH(WIDTH), .CHANS(NUM_CHAN)) u_disagree (
        .chans(chan_vec), .ref_word(pick_word), .flags(flag_vec)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.word = pick_word;
            state_d.dis  = flag_vec;
            state_d.any  = |flag_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid = state_q.vld;
    assign voted     = state_q.word;
    assign disagree  = state_q.dis;
    assign any_fault = state_q.any;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                          // R7
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                        // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(voted) && $stable(disagree) && $stable(any_fault))); // R8
    AST_PAIR_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode && chan_a == chan_b) |=> (voted == $past(chan_a)));     // R2
    AST_PAIR_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode && (chan_a == chan_b || chan_a == chan_c || chan_b == chan_c))
        |=> $onehot0(disagree));                                          // R5
    AST_MEDIAN_IS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode) |=> (voted == $past(chan_a) || voted == $past(chan_b)
                                || voted == $past(chan_c)));              // R3
    AST_MEDIAN_KEEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode) |=> ($countones(disagree) <= 2));              // R4
    AST_FAULT_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (any_fault == (disagree != 3'b000)));               // R6
endmodule

// File: tb/tmr_voter_bench.sv
module tmr_voter_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         mode = 1'b0;
    logic [W-1:0] chan_a = '0, chan_b = '0, chan_c = '0;
    logic         out_valid;
    logic [W-1:0] voted;
    logic [2:0]   disagree;
    logic         any_fault;

    int n_checks = 0;
    int n_fail   = 0;

    // reference model state
    logic         m_vld = 1'b0;
    logic [W-1:0] m_word = '0;
    logic [2:0]   m_dis = '0;
    logic         m_any = 1'b0;

    always #4 clk = ~clk;

    tmr_voter #(.WIDTH(W)) u_tmr_voter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .chan_a(chan_a), .chan_b(chan_b), .chan_c(chan_c),
        .out_valid(out_valid), .voted(voted), .disagree(disagree),
        .any_fault(any_fault)
    );

    function automatic logic [W-1:0] ref_major(input logic [W-1:0] a, b, c);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            int ones;
            ones = int'(a[i]) + int'(b[i]) + int'(c[i]);
            r[i] = (ones >= 2);
        end
        return r;
    endfunction

    function automatic logic [W-1:0] ref_median(input logic [W-1:0] a, b, c);
        int v[3];
        v[0] = int'(a); v[1] = int'(b); v[2] = int'(c);
        for (int p = 0; p < 2; p++)
            for (int q = 0; q < 2 - p; q++)
                if (v[q] > v[q+1]) begin
                    int t;
                    t = v[q]; v[q] = v[q+1]; v[q+1] = t;
                end
        return W'(v[1]);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, "voted", int'(voted), int'(m_word));
        check("R5", "disagree", int'(disagree), int'(m_dis));
        check("R6", "any_fault", int'(any_fault), int'(m_any));
        check("R7", "out_valid", int'(out_valid), int'(m_vld));
    endtask

    // drive one sample, advance the model on the edge, compare at the next falling edge
    task automatic step(input logic [W-1:0] a, b, c, input logic md, input logic v,
                        input string tag);
        @(negedge clk);
        chan_a = a; chan_b = b; chan_c = c; mode = md; in_valid = v;
        @(negedge clk);
        m_vld = v;
        if (v) begin
            m_word = md ? ref_median(a, b, c) : ref_major(a, b, c);
            m_dis  = {c != m_word, b != m_word, a != m_word};
            m_any  = |m_dis;
        end
        compare_all(tag);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] bases [4] = '{16'h0000, 16'hFFFF, 16'hA5C3, 16'h1234};
        logic [W-1:0] masks [4] = '{16'h0001, 16'h8000, 16'h00F0, 16'hFFFF};

        repeat (3) @(negedge clk);
        // R9: reset state, with busy inputs applied
        chan_a = 16'h1111; chan_b = 16'h2222; chan_c = 16'h3333; in_valid = 1'b1;
        @(negedge clk);
        check("R9", "out_valid", int'(out_valid), 0);
        check("R9", "voted", int'(voted), 0);
        check("R9", "disagree", int'(disagree), 0);
        check("R9", "any_fault", int'(any_fault), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;

        // R1: bit-level majority with all channels different
        step(16'hF0F0, 16'hCCCC, 16'hAAAA, 1'b0, 1'b1, "R1");
        check("R1", "explicit", int'(voted), int'(16'hE8E8));
        step(16'h0001, 16'h0002, 16'h0004, 1'b0, 1'b1, "R1");

        // R2/R3: every single-channel corruption in both modes
        for (int md = 0; md < 2; md++)
            for (int ch = 0; ch < 3; ch++)
                for (int bi = 0; bi < 4; bi++)
                    for (int mi = 0; mi < 4; mi++) begin
                        logic [W-1:0] a, b, c, bad;
                        a = bases[bi]; b = bases[bi]; c = bases[bi];
                        bad = bases[bi] ^ masks[mi];
                        if (ch == 0) a = bad; else if (ch == 1) b = bad; else c = bad;
                        step(a, b, c, md[0], 1'b1, md == 0 ? "R2" : "R3");
                        if (md == 0) check("R2", "masked", int'(voted), int'(bases[bi]));
                    end

        // R3: outlier reading discarded
        step(16'd99, 16'd100, 16'd45217, 1'b1, 1'b1, "R3");
        check("R3", "explicit median", int'(voted), 100);
        step(16'd45217, 16'd99, 16'd100, 1'b1, 1'b1, "R3");
        check("R3", "explicit median", int'(voted), 100);
        step(16'd7, 16'd65535, 16'd300, 1'b1, 1'b1, "R3");

        // R4: ties in median mode
        step(16'd5, 16'd5, 16'd900, 1'b1, 1'b1, "R4");
        check("R4", "tie value", int'(voted), 5);
        check("R4", "tie flags", int'(disagree), 3'b100);
        step(16'd900, 16'd5, 16'd900, 1'b1, 1'b1, "R4");
        check("R4", "tie value", int'(voted), 900);
        step(16'd42, 16'd42, 16'd42, 1'b1, 1'b1, "R4");
        check("R6", "all agree", int'(any_fault), 0);

        // R8: idle cycles leave the result untouched
        step(16'hBEEF, 16'h0000, 16'hFFFF, 1'b0, 1'b0, "R8");
        check("R8", "held value", int'(voted), 42);
        step(16'h1, 16'h2, 16'h3, 1'b1, 1'b0, "R8");
        check("R8", "held flags", int'(disagree), 0);

        // R7: back-to-back samples
        step(16'h00FF, 16'h00FF, 16'h0F0F, 1'b0, 1'b1, "R7");
        step(16'h3000, 16'h2000, 16'h1000, 1'b1, 1'b1, "R7");
        check("R7", "second sample", int'(voted), int'(16'h2000));

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule